// File: doc/BRIEF.md
# Banked Scratchpad With Conflict Serialization

This block is a multi-lane on-chip scratchpad built from independent banks, each one word wide. A group of lanes, called a warp, presents a single request. In that request every lane carries an active flag, a write flag, a word address and write data. The low bits of a word address select the bank. The remaining bits select the row inside that bank. The block checks each bank for conflicts, meaning active lanes that want different words from the same bank. It serves those words one after another in passes, and each pass occupies a two-cycle bank slot. Lanes that want the same word share one bank access, so a broadcast or multicast read costs no extra pass.

A controller in the top module walks through four states. IDLE holds `req_ready` high and accepts a request. ACCESS is the first cycle of a slot, in which every bank reads the word picked for it. SETTLE is the second cycle: the read words go to the lanes they serve, and any write to those words commits. DONE raises `done` for one cycle while all lane read data and the pass count are valid. The transitions are these. IDLE goes to ACCESS when it accepts a request with at least one active lane. IDLE goes to DONE when it accepts a request with no active lane. ACCESS always goes to SETTLE. SETTLE goes back to ACCESS while some lanes remain unserved, and goes to DONE once all are served. DONE always returns to IDLE.

In each pass, every bank picks the word wanted by its lowest-numbered unserved lane, and it completes every lane that wants that word. The number of passes therefore equals the largest count of distinct words requested from any single bank.

Top module: `banked_scratchpad`

## Requirements
- R1: Bank = word address modulo BANKS (the low log2(BANKS) address bits) and row = the remaining upper bits. An active lane reading a word receives the value most recently written to that word address.
- R2: `req_ready` is high only in IDLE. A request presented while the block is busy is not accepted, so its writes never reach the memory.
- R3: `rsp_passes`, valid while `done` is high, equals the largest number of distinct word addresses that active lanes request from any one bank.
- R4: Active lanes that request the same word share one access. A request in which every lane reads one word (broadcast), or in which lanes read repeated words one per bank (multicast), completes in one pass.
- R5: Each pass takes two cycles. `done` is high in the cycle after the 2×P-th rising edge that follows the accepting edge, where P is the pass count.
- R6: `done` is high for exactly one cycle, and `req_ready` is high again in the next cycle.
- R7: Inactive lanes are ignored. They return zero read data, add no pass and write nothing. A request with no active lane reaches DONE at the accepting edge with a pass count of zero.
- R8: When several active lanes write the same word in one request, the word afterwards holds the data of the highest-numbered of those lanes.
- R9: Every active lane, whether it reads or writes, receives the word's content from before the request. Writes in one request become visible to later requests.
- R10: After reset, `req_ready` is 1, `done` is 0, `rsp_rdata` is all zero and `rsp_passes` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_active | input | LANES | Per-lane active flag |
| req_write | input | LANES | Per-lane write flag (1 = write, 0 = read) |
| req_addr | input | LANES*ADDR_W | Per-lane word address, lane 0 in the low bits |
| req_wdata | input | LANES*DATA_W | Per-lane write data, lane 0 in the low bits |
| done | output | 1 | One-cycle completion strobe |
| rsp_rdata | output | LANES*DATA_W | Per-lane read data, lane 0 in the low bits |
| rsp_passes | output | PASS_W | Number of passes the request used |

## Verification
The bench builds the block with 8 lanes, 4 banks and 8 rows of 32-bit words, which gives a 32-word memory in which every word can be preloaded and tracked by a model. With only four banks, two lanes already share a bank under linear addressing. All eight lanes can land on different rows of one bank, which drives the worst case of eight serialized passes. The same setup also reaches multicast, write-winner and stale-read cases with short address lists.

// File: rtl/bsp_pkg.sv
package bsp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCESS = 2'd1,
        ST_SETTLE = 2'd2,
        ST_DONE   = 2'd3
    } bsp_state_e;

endpackage

// File: rtl/bsp_bank_mem.sv
module bsp_bank_mem #(
    parameter int ROWS   = 8,
    parameter int DATA_W = 32,
    parameter int ROW_W  = $clog2(ROWS)
) (
    input  logic              clk,
    input  logic              rd_en,
    input  logic [ROW_W-1:0]  rd_row,
    input  logic              wr_en,
    input  logic [ROW_W-1:0]  wr_row,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] store [ROWS];

    // Synchronous read port; the write lands in a different slot cycle.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[wr_row] <= wr_data;
        end
        if (rd_en) begin
            rd_data <= store[rd_row];
        end
    end

endmodule

// File: rtl/bsp_bank_pick.sv
module bsp_bank_pick #(
    parameter int LANES   = 32,
    parameter int BANK_W  = 5,
    parameter int ROW_W   = 3,
    parameter int DATA_W  = 32,
    parameter int BANK_ID = 0
) (
    input  logic [LANES-1:0]             pending,
    input  logic [LANES-1:0][BANK_W-1:0] lane_bank,
    input  logic [LANES-1:0][ROW_W-1:0]  lane_row,
    input  logic [LANES-1:0]             lane_wr,
    input  logic [LANES-1:0][DATA_W-1:0] lane_wdata,
    output logic                         pick_valid,
    output logic [ROW_W-1:0]             pick_row,
    output logic [LANES-1:0]             serve,
    output logic                         wr_en,
    output logic [DATA_W-1:0]            wr_data
);

    localparam logic [BANK_W-1:0] BANK_SEL = BANK_W'(BANK_ID);

    logic [LANES-1:0] in_bank;

    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            in_bank[l] = pending[l] && (lane_bank[l] == BANK_SEL);
        end
    end

    // The lowest-numbered unserved lane in this bank chooses the word.
    always_comb begin
        pick_valid = 1'b0;
        pick_row   = '0;
        for (int l = 0; l < LANES; l++) begin
            if (!pick_valid && in_bank[l]) begin
                pick_valid = 1'b1;
                pick_row   = lane_row[l];
            end
        end
    end

    // Every lane wanting the chosen word rides along. Ascending scan lets the
    // highest-numbered writer overwrite the lower ones.
    always_comb begin
        serve   = '0;
        wr_en   = 1'b0;
        wr_data = '0;
        for (int l = 0; l < LANES; l++) begin
            if (pick_valid && in_bank[l] && (lane_row[l] == pick_row)) begin
                serve[l] = 1'b1;
                if (lane_wr[l]) begin
                    wr_en   = 1'b1;
                    wr_data = lane_wdata[l];
                end
            end
        end
    end

endmodule

// File: rtl/banked_scratchpad.sv
module banked_scratchpad
    import bsp_pkg::*;
#(
    parameter int LANES  = 32,
    parameter int BANKS  = 32,
    parameter int ROWS   = 8,
    parameter int DATA_W = 32,
    localparam int BANK_W = $clog2(BANKS),
    localparam int ROW_W  = $clog2(ROWS),
    localparam int ADDR_W = BANK_W + ROW_W,
    localparam int PASS_W = $clog2(LANES + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [LANES-1:0]         req_active,
    input  logic [LANES-1:0]         req_write,
    input  logic [LANES*ADDR_W-1:0]  req_addr,
    input  logic [LANES*DATA_W-1:0]  req_wdata,
    output logic                     done,
    output logic [LANES*DATA_W-1:0]  rsp_rdata,
    output logic [PASS_W-1:0]        rsp_passes
);

    bsp_state_e state_q, state_d;

    logic [LANES-1:0]             wr_q;
    logic [LANES-1:0]             pending_q;
    logic [LANES-1:0][BANK_W-1:0] bank_q;
    logic [LANES-1:0][ROW_W-1:0]  row_q;
    logic [LANES-1:0][DATA_W-1:0] wdata_q;
    logic [LANES-1:0][DATA_W-1:0] rdata_q;
    logic [PASS_W-1:0]            passes_q;

    logic [BANKS-1:0]             pick_valid;
    logic [ROW_W-1:0]             pick_row   [BANKS];
    logic [LANES-1:0]             serve_m    [BANKS];
    logic [BANKS-1:0]             bank_wr_en;
    logic [DATA_W-1:0]            bank_wdata [BANKS];
    logic [DATA_W-1:0]            bank_rdata [BANKS];
    logic [LANES-1:0]             served;
    logic [LANES-1:0]             left_after;

    // ---------------- per-bank selection and storage ----------------
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        bsp_bank_pick #(
            .LANES  (LANES),
            .BANK_W (BANK_W),
            .ROW_W  (ROW_W),
            .DATA_W (DATA_W),
            .BANK_ID(b)
        ) u_pick (
            .pending   (pending_q),
            .lane_bank (bank_q),
            .lane_row  (row_q),
            .lane_wr   (wr_q),
            .lane_wdata(wdata_q),
            .pick_valid(pick_valid[b]),
            .pick_row  (pick_row[b]),
            .serve     (serve_m[b]),
            .wr_en     (bank_wr_en[b]),
            .wr_data   (bank_wdata[b])
        );

        bsp_bank_mem #(
            .ROWS  (ROWS),
            .DATA_W(DATA_W),
            .ROW_W (ROW_W)
        ) u_mem (
            .clk    (clk),
            .rd_en  ((state_q == ST_ACCESS) && pick_valid[b]),
            .rd_row (pick_row[b]),
            .wr_en  ((state_q == ST_SETTLE) && bank_wr_en[b]),
            .wr_row (pick_row[b]),
            .wr_data(bank_wdata[b]),
            .rd_data(bank_rdata[b])
        );
    end

    always_comb begin
        served = '0;
        for (int b = 0; b < BANKS; b++) begin
            served = served | serve_m[b];
        end
        left_after = pending_q & ~served;
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    state_d = (req_active == '0) ? ST_DONE : ST_ACCESS;
                end
            end
            ST_ACCESS: state_d = ST_SETTLE;
            ST_SETTLE: state_d = (left_after == '0) ? ST_DONE : ST_ACCESS;
            ST_DONE:   state_d = ST_IDLE;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- request and result registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q      <= '0;
            pending_q <= '0;
            bank_q    <= '0;
            row_q     <= '0;
            wdata_q   <= '0;
            rdata_q   <= '0;
            passes_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        wr_q      <= req_write;
                        pending_q <= req_active;
                        rdata_q   <= '0;
                        passes_q  <= '0;
                        for (int l = 0; l < LANES; l++) begin
                            bank_q[l]  <= req_addr[l*ADDR_W +: BANK_W];
                            row_q[l]   <= req_addr[l*ADDR_W + BANK_W +: ROW_W];
                            wdata_q[l] <= req_wdata[l*DATA_W +: DATA_W];
                        end
                    end
                end
                ST_ACCESS: begin
                end
                ST_SETTLE: begin
                    for (int l = 0; l < LANES; l++) begin
                        if (served[l]) begin
                            rdata_q[l] <= bank_rdata[bank_q[l]];
                        end
                    end
                    pending_q <= left_after;
                    passes_q  <= passes_q + 1'b1;
                end
                ST_DONE: begin
                end
            endcase
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        req_ready  = (state_q == ST_IDLE);
        done       = (state_q == ST_DONE);
        rsp_rdata  = rdata_q;
        rsp_passes = passes_q;
    end

endmodule

// File: rtl/banked_scratchpad_chk.sv
module banked_scratchpad_chk #(
    parameter int LANES  = 32,
    parameter int DATA_W = 32,
    parameter int PASS_W = 6
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    req_valid,
    input logic                    req_ready,
    input logic [LANES-1:0]        req_active,
    input logic                    done,
    input logic [LANES*DATA_W-1:0] rsp_rdata,
    input logic [PASS_W-1:0]       rsp_passes
);

    logic [LANES-1:0]        act_seen;
    logic [15:0]             busy_cnt;
    logic [LANES*DATA_W-1:0] idle_mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_seen <= '0;
            busy_cnt <= '0;
        end else if (req_valid && req_ready) begin
            act_seen <= req_active;
            busy_cnt <= '0;
        end else if (!req_ready && busy_cnt != 16'hFFFF) begin
            busy_cnt <= busy_cnt + 16'd1;
        end
    end

    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            idle_mask[l*DATA_W +: DATA_W] = {DATA_W{~act_seen[l]}};
        end
    end

    p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    p_done_not_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req_ready);

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready));

    p_pass_timing_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy_cnt == (16'(rsp_passes) << 1)));

    p_pass_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((act_seen != '0) == (rsp_passes != '0)));

    p_pass_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (32'(rsp_passes) <= 32'($countones(act_seen))));

    p_inactive_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((rsp_rdata & idle_mask) == '0));

endmodule

bind banked_scratchpad banked_scratchpad_chk #(
    .LANES (LANES),
    .DATA_W(DATA_W),
    .PASS_W(PASS_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_active(req_active),
    .done      (done),
    .rsp_rdata (rsp_rdata),
    .rsp_passes(rsp_passes)
);

// File: tb/banked_scratchpad_bench.sv
module banked_scratchpad_bench;

    localparam int LANES  = 8;
    localparam int BANKS  = 4;
    localparam int ROWS   = 8;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 5;
    localparam int PASS_W = 4;
    localparam int WORDS  = BANKS * ROWS;
    localparam int NVEC   = 16;

    // Vector: [59:52] active, [51:44] write, [43:4] addresses lane7..lane0, [3:0] passes
    localparam logic [59:0] VEC [NVEC] = '{
        // 0-3: fill memory, two lanes per bank -> 2 passes (R1)
        {8'hFF, 8'hFF, {5'd7, 5'd6, 5'd5, 5'd4, 5'd3, 5'd2, 5'd1, 5'd0}, 4'd2},
        {8'hFF, 8'hFF, {5'd15,5'd14,5'd13,5'd12,5'd11,5'd10,5'd9, 5'd8}, 4'd2},
        {8'hFF, 8'hFF, {5'd23,5'd22,5'd21,5'd20,5'd19,5'd18,5'd17,5'd16},4'd2},
        {8'hFF, 8'hFF, {5'd31,5'd30,5'd29,5'd28,5'd27,5'd26,5'd25,5'd24},4'd2},
        // 4: multicast, R4
        {8'hFF, 8'h00, {5'd3, 5'd2, 5'd1, 5'd0, 5'd3, 5'd2, 5'd1, 5'd0}, 4'd1},
        // 5: broadcast, R4
        {8'hFF, 8'h00, {8{5'd9}}, 4'd1},
        // 6: all lanes distinct rows of bank 2, R3 worst case
        {8'hFF, 8'h00, {5'd30,5'd26,5'd22,5'd18,5'd14,5'd10,5'd6, 5'd2}, 4'd8},
        // 7: mixed loads: bank0 3 words, bank1 2, bank3 1 -> 3 passes, R3
        {8'hFF, 8'h00, {5'd3, 5'd5, 5'd1, 5'd1, 5'd12,5'd4, 5'd8, 5'd4}, 4'd3},
        // 8: only lanes 0,2 active; inactive lanes try writes, R7
        {8'h05, 8'hFA, {5'd31,5'd27,5'd23,5'd19,5'd15,5'd7, 5'd11,5'd3}, 4'd2},
        // 9: lanes 1,3,6 write word 13, lane 0 reads it, R8 and R9
        {8'h4B, 8'h4A, {8{5'd13}}, 4'd1},
        // 10: read back word 13, lane 6 data expected, R8
        {8'hFF, 8'h00, {8{5'd13}}, 4'd1},
        // 11: no active lane, writes flagged but ignored, R7
        {8'h00, 8'hFF, {8{5'd0}}, 4'd0},
        // 12: words touched by inactive writers still hold old data, R7
        {8'hFF, 8'h00, {5'd31,5'd27,5'd23,5'd19,5'd15,5'd11,5'd7, 5'd3}, 4'd8},
        // 13: read and write of words 20/21 in one request, R9
        {8'h0F, 8'h06, {5'd0, 5'd0, 5'd0, 5'd0, 5'd21,5'd21,5'd20,5'd20},4'd1},
        // 14: new values of 20/21 visible, R9
        {8'h03, 8'h00, {5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd21,5'd20}, 4'd1},
        // 15: word 0 untouched by vector 11, R7
        {8'hFF, 8'h00, {5'd7, 5'd6, 5'd5, 5'd4, 5'd3, 5'd2, 5'd1, 5'd0}, 4'd2}
    };

    logic                      clk = 1'b0;
    logic                      rst_n = 1'b0;
    logic                      req_valid = 1'b0;
    logic                      req_ready;
    logic [LANES-1:0]          req_active = '0;
    logic [LANES-1:0]          req_write = '0;
    logic [LANES*ADDR_W-1:0]   req_addr = '0;
    logic [LANES*DATA_W-1:0]   req_wdata = '0;
    logic                      done;
    logic [LANES*DATA_W-1:0]   rsp_rdata;
    logic [PASS_W-1:0]         rsp_passes;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    logic [DATA_W-1:0] model [WORDS];

    always #10 clk = ~clk;

    banked_scratchpad #(
        .LANES (LANES),
        .BANKS (BANKS),
        .ROWS  (ROWS),
        .DATA_W(DATA_W)
    ) u_banked_scratchpad (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_active(req_active),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .done      (done),
        .rsp_rdata (rsp_rdata),
        .rsp_passes(rsp_passes)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 50000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run hung, cycles %0d expected below 50000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [DATA_W-1:0] wdata_of(input int vid, input int lane);
        return 32'h5A00_0000 + 32'(vid) * 32'd256 + 32'(lane);
    endfunction

    task automatic run_req(input logic [7:0] act, input logic [7:0] wr,
                           input logic [39:0] addr, input int exp_p,
                           input int vid, input bit intrude);
        logic [DATA_W-1:0] exp_rd [LANES];
        logic [LANES*DATA_W-1:0] wd;
        int edges;
        for (int l = 0; l < LANES; l++) begin
            exp_rd[l] = act[l] ? model[addr[l*ADDR_W +: ADDR_W]] : '0;
            wd[l*DATA_W +: DATA_W] = wdata_of(vid, l);
        end
        for (int l = 0; l < LANES; l++) begin
            if (act[l] && wr[l]) model[addr[l*ADDR_W +: ADDR_W]] = wdata_of(vid, l);
        end
        @(negedge clk);
        check(req_ready == 1'b1, "R2 ready before request", 64'(req_ready), 64'd1);
        req_active = act;
        req_write  = wr;
        req_addr   = addr;
        req_wdata  = wd;
        req_valid  = 1'b1;
        @(posedge clk);
        @(negedge clk);
        if (intrude) begin
            // R2: a write request presented while busy must not be taken
            req_active = '1;
            req_write  = '1;
            req_addr   = {LANES{5'd2}};
            req_wdata  = {LANES{32'hDEAD_BEEF}};
        end else begin
            req_valid = 1'b0;
        end
        edges = 0;
        while (!done && edges < 200) begin
            if (edges == 3) req_valid = 1'b0;
            @(posedge clk);
            edges++;
            @(negedge clk);
        end
        req_valid = 1'b0;
        check(done == 1'b1, "R5 done reached", 64'(done), 64'd1);
        check(edges == 2 * exp_p, "R5 cycles to done", 64'(edges), 64'(2 * exp_p));
        check(rsp_passes == PASS_W'(exp_p), "R3 pass count", 64'(rsp_passes), 64'(exp_p));
        check(req_ready == 1'b0, "R2 ready low at done", 64'(req_ready), 64'd0);
        for (int l = 0; l < LANES; l++) begin
            if (act[l])
                check(rsp_rdata[l*DATA_W +: DATA_W] == exp_rd[l], "R1 lane read data",
                      64'(rsp_rdata[l*DATA_W +: DATA_W]), 64'(exp_rd[l]));
            else
                check(rsp_rdata[l*DATA_W +: DATA_W] == '0, "R7 inactive lane data",
                      64'(rsp_rdata[l*DATA_W +: DATA_W]), 64'd0);
        end
        @(posedge clk);
        @(negedge clk);
        check(!done && req_ready, "R6 single done then ready",
              64'({done, req_ready}), 64'b01);
    endtask

    initial begin
        for (int w = 0; w < WORDS; w++) model[w] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset values
        check(req_ready == 1'b1, "R10 ready in reset", 64'(req_ready), 64'd1);
        check(done == 1'b0, "R10 done in reset", 64'(done), 64'd0);
        check(rsp_rdata == '0, "R10 rdata in reset", 64'(rsp_rdata[63:0]), 64'd0);
        check(rsp_passes == '0, "R10 passes in reset", 64'(rsp_passes), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1 && done == 1'b0, "R10 idle after reset",
              64'({req_ready, done}), 64'b10);

        for (int v = 0; v < NVEC; v++) begin
            run_req(VEC[v][59:52], VEC[v][51:44], VEC[v][43:4], int'(VEC[v][3:0]), v, 1'b0);
        end

        // R2: long request with a competing write held while busy,
        // then word 2 read back must keep its old value
        run_req(VEC[6][59:52], VEC[6][51:44], VEC[6][43:4], 8, 20, 1'b1);
        run_req(8'hFF, 8'h00, {LANES{5'd2}}, 1, 21, 1'b0);

        // R8: four lanes write word 30 (bank 2), highest lane 7 must win
        run_req(8'hF0, 8'hF0, {{4{5'd30}}, {4{5'd0}}}, 1, 22, 1'b0);
        run_req(8'h01, 8'h00, {{7{5'd0}}, 5'd30}, 1, 23, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule